// File: doc/BRIEF.md
# Paging Batch Synchronization Controller

This controller keeps a paging receiver locked to a batched codeword stream while using as little receiver on-time as it can. Each batch is 544 bits: one 32-bit sync codeword (codeword slot 0) followed by eight two-codeword frames (slots 1 to 16). A bit-recovery stage supplies a one-cycle strobe per received bit. Detector stages supply pulses for preamble seen, sync word completed and uncorrectable codeword. These pulses are read only in a cycle where the bit strobe is high.

The controller counts the bit and codeword position inside the batch. It moves through six modes (switch-on, preamble receive, data receive, data fail, fade recovery, carrier off) and drives a receiver-enable output whose on-windows depend on the mode. Turning the block off returns it to an idle state. A forced-termination command sends any active mode to data fail.

Mode codes on `mode`: 0 idle, 1 switch-on, 2 preamble receive, 3 data receive, 4 data fail, 5 fade recovery, 6 carrier off. The batch position is p = 32·`cw_pos` + `bit_pos`.

Top module: `batch_sync_ctrl`

## Requirements
- R1: While `en` is low the next state is idle (mode 0) with `rx_en` low and both position outputs 0. Strobes and detections in idle have no effect.
- R2: One cycle after `en` is high in idle, mode is 1 (switch-on) with position 0. `rx_en` is held high throughout switch-on (mode 1) and preamble receive (mode 2).
- R3: Each bit strobe advances `bit_pos` 0..31. When it wraps, `cw_pos` advances 0..16 and then back to 0. Without a strobe the position holds.
- R4: In switch-on, a sync pulse leads to mode 3 and a preamble pulse leads to mode 2. The 1632nd strobe after entry (3 batches) with neither pulse leads to mode 6.
- R5: In preamble receive, a sync pulse leads to mode 3. The 544th strobe since entry or since the last preamble pulse, without a pulse, leads to mode 6.
- R6: The strobe that accepts a sync word into data receive sets the position to codeword 1, bit 0.
- R7: In data receive `rx_en` is high in codeword 0, and in codewords 2k+1 and 2k+2 exactly when `frame_mask[k]` is 1.
- R8: An uncorrectable pulse in data receive leads to mode 4. In data fail `rx_en` follows the R7 rule.
- R9: In data fail, only the strobe at codeword 0, bit 31 decides the next mode: mode 3 if sync is pulsed, otherwise mode 5. At all other strobes the sync and uncorrectable pulses are ignored.
- R10: In fade recovery `rx_en` is high for p ≥ 536 or p ≤ 39. Sync (to mode 3) and preamble (to mode 2) are accepted only at strobes with 23 ≤ p ≤ 39. The 8160th strobe after entry (15 batches) leads to mode 6.
- R11: Entering carrier off clears `bit_pos`. `rx_en` is then high for the first 32 of every 576 strobes (1 codeword in 18). Sync (to mode 3) and preamble (to mode 2) are accepted only while `rx_en` is high.
- R12: A `force_term` cycle in any active mode leads to mode 4 on the next cycle, ahead of any detection in that cycle.
- R13: When a detection and a mode timeout fall on the same strobe, the detection decides the next mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | On/off control |
| bit_stb | input | 1 | One-cycle pulse per recovered bit |
| pre_det | input | 1 | Preamble detected (valid with bit_stb) |
| sync_det | input | 1 | Sync word completed on this bit (valid with bit_stb) |
| uncorr_det | input | 1 | Uncorrectable codeword (valid with bit_stb) |
| force_term | input | 1 | Forced call termination command |
| frame_mask | input | 8 | Frames with receiver enabled in data modes |
| rx_en | output | 1 | Receiver enable |
| mode | output | 3 | Current mode code |
| bit_pos | output | 5 | Bit index within codeword |
| cw_pos | output | 5 | Codeword index within batch |

## Verification
A detection pulse and a batch-count timeout can fall on the same strobe. The bench provokes this by running switch-on to its 1632nd strobe and pulsing sync exactly there. It then expects data receive, not carrier off. A forced termination can also coincide with a sync word at the expected data-fail position. The bench drives both in one cycle and expects the block to stay in data fail.

// File: rtl/batch_sync_ctrl.sv
module batch_sync_ctrl #(
  parameter int CW_BITS      = 32,
  parameter int CW_PER_BATCH = 17,
  parameter int FRAMES       = 8,
  parameter int SWON_BATCHES = 3,
  parameter int FADE_BATCHES = 15,
  parameter int FADE_WIN     = 8,
  parameter int SCAN_CW      = 18,
  localparam int BW = $clog2(CW_BITS),
  localparam int CWW = $clog2(CW_PER_BATCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_stb,
  input  logic              pre_det,
  input  logic              sync_det,
  input  logic              uncorr_det,
  input  logic              force_term,
  input  logic [FRAMES-1:0] frame_mask,
  output logic              rx_en,
  output logic [2:0]        mode,
  output logic [BW-1:0]     bit_pos,
  output logic [CWW-1:0]    cw_pos
);
  localparam int BATCH_BITS = CW_BITS * CW_PER_BATCH;
  localparam int PW = $clog2(BATCH_BITS);
  localparam int TW = $clog2(FADE_BATCHES * BATCH_BITS + 1);
  localparam int SW = $clog2(SCAN_CW);
  localparam int FW = $clog2(FRAMES);
  localparam logic [BW-1:0]  BIT_LAST  = BW'(CW_BITS - 1);
  localparam logic [CWW-1:0] CW_LAST   = CWW'(CW_PER_BATCH - 1);
  localparam logic [CWW-1:0] CW_ONE    = CWW'(1);
  localparam logic [SW-1:0]  SCAN_LAST = SW'(SCAN_CW - 1);
  localparam logic [PW-1:0]  WIN_LO    = PW'(CW_BITS - 1 - FADE_WIN);
  localparam logic [PW-1:0]  WIN_HI    = PW'(CW_BITS - 1 + FADE_WIN);
  localparam logic [PW-1:0]  RXF_LO    = PW'(BATCH_BITS - FADE_WIN);
  localparam logic [TW-1:0]  SWON_LIM  = TW'(SWON_BATCHES * BATCH_BITS - 1);
  localparam logic [TW-1:0]  PRE_LIM   = TW'(BATCH_BITS - 1);
  localparam logic [TW-1:0]  FADE_LIM  = TW'(FADE_BATCHES * BATCH_BITS - 1);
  localparam logic [TW-1:0]  TMR_MAX   = {TW{1'b1}};

  typedef enum logic [2:0] {
    M_IDLE = 3'd0, M_SWON = 3'd1, M_PRE = 3'd2, M_DATA = 3'd3,
    M_FAIL = 3'd4, M_FADE = 3'd5, M_COFF = 3'd6
  } mode_t;

  mode_t          st, nx;
  logic [BW-1:0]  bit_cnt;
  logic [CWW-1:0] cw_cnt;
  logic [TW-1:0]  tmr;
  logic [SW-1:0]  scan;
  logic [PW-1:0]  pos;
  logic [CWW-1:0] fidx;
  logic           last_bit, sync_end, in_win, s_sync, s_pre, realign, enter_coff;

  assign pos      = PW'(cw_cnt) * PW'(CW_BITS) + PW'(bit_cnt);
  assign fidx     = (cw_cnt - CW_ONE) >> 1;
  assign last_bit = bit_cnt == BIT_LAST;
  assign sync_end = cw_cnt == '0 && last_bit;
  assign in_win   = pos >= WIN_LO && pos <= WIN_HI;
  assign s_sync   = bit_stb && sync_det;
  assign s_pre    = bit_stb && pre_det;

  always_comb begin
    nx = st;
    if (!en) nx = M_IDLE;
    else if (st == M_IDLE) nx = M_SWON;
    else if (force_term) nx = M_FAIL;
    else if (bit_stb) begin
      case (st)
        M_SWON: if (sync_det) nx = M_DATA;
                else if (pre_det) nx = M_PRE;
                else if (tmr == SWON_LIM) nx = M_COFF;
        M_PRE:  if (sync_det) nx = M_DATA;
                else if (!pre_det && tmr == PRE_LIM) nx = M_COFF;
        M_DATA: if (uncorr_det) nx = M_FAIL;
        M_FAIL: if (sync_end) nx = sync_det ? M_DATA : M_FADE;
        M_FADE: if (in_win && sync_det) nx = M_DATA;
                else if (in_win && pre_det) nx = M_PRE;
                else if (tmr == FADE_LIM) nx = M_COFF;
        M_COFF: if (scan == '0 && sync_det) nx = M_DATA;
                else if (scan == '0 && pre_det) nx = M_PRE;
        default: nx = M_IDLE;
      endcase
    end
  end

  assign realign    = s_sync && nx == M_DATA && (st != M_DATA || sync_end);
  assign enter_coff = nx == M_COFF && st != M_COFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_IDLE; bit_cnt <= '0; cw_cnt <= '0; tmr <= '0; scan <= '0;
    end else begin
      st <= nx;
      if (nx == M_IDLE || st == M_IDLE) begin
        bit_cnt <= '0; cw_cnt <= '0; tmr <= '0; scan <= '0;
      end else begin
        if (realign) begin
          bit_cnt <= '0; cw_cnt <= CW_ONE;
        end else if (enter_coff) begin
          bit_cnt <= '0;
        end else if (bit_stb) begin
          bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
          if (last_bit) cw_cnt <= (cw_cnt == CW_LAST) ? '0 : cw_cnt + 1'b1;
        end
        if (nx != st || (st == M_PRE && s_pre)) tmr <= '0;
        else if (bit_stb && tmr != TMR_MAX) tmr <= tmr + 1'b1;
        if (enter_coff) scan <= '0;
        else if (st == M_COFF && bit_stb && last_bit)
          scan <= (scan == SCAN_LAST) ? '0 : scan + 1'b1;
      end
    end
  end

  always_comb begin
    case (st)
      M_SWON, M_PRE:  rx_en = 1'b1;
      M_DATA, M_FAIL: rx_en = (cw_cnt == '0) || frame_mask[fidx[FW-1:0]];
      M_FADE:         rx_en = (pos >= RXF_LO) || (pos <= WIN_HI);
      M_COFF:         rx_en = scan == '0;
      default:        rx_en = 1'b0;
    endcase
  end

  assign mode    = st;
  assign bit_pos = bit_cnt;
  assign cw_pos  = cw_cnt;

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (mode == 3'd0 && !rx_en && bit_pos == '0 && cw_pos == '0)); // R1
  AST_SWITCH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 3'd0) |=> (mode == 3'd1 && bit_pos == '0 && cw_pos == '0)); // R2
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= BIT_LAST && cw_pos <= CW_LAST); // R3
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode != 3'd0 && !bit_stb && !force_term) |=> ($stable(bit_pos) && $stable(cw_pos))); // R3
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !force_term && mode == 3'd4 && !(bit_stb && sync_end)) |=> mode == 3'd4); // R9
  AST_SCAN_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !force_term && mode == 3'd6 && !rx_en) |=> mode == 3'd6); // R11
  AST_FORCE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode != 3'd0 && force_term) |=> mode == 3'd4); // R12
endmodule

// File: tb/batch_sync_ctrl_tb.sv
module batch_sync_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, bit_stb = 1'b0;
  logic pre_det = 1'b0, sync_det = 1'b0, uncorr_det = 1'b0, force_term = 1'b0;
  logic [7:0] frame_mask = 8'b0000_0100;
  logic rx_en;
  logic [2:0] mode;
  logic [4:0] bit_pos, cw_pos;
  int checks = 0, fails = 0, tp = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  batch_sync_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_stb(bit_stb), .pre_det(pre_det),
    .sync_det(sync_det), .uncorr_det(uncorr_det), .force_term(force_term),
    .frame_mask(frame_mask), .rx_en(rx_en), .mode(mode), .bit_pos(bit_pos), .cw_pos(cw_pos)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(string req);
    chk(req, int'(cw_pos) * 32 + int'(bit_pos), tp);
  endtask

  task automatic step(bit p, bit s, bit u, bit f);
    @(negedge clk);
    bit_stb = 1'b1; pre_det = p; sync_det = s; uncorr_det = u; force_term = f;
    @(negedge clk);
    bit_stb = 1'b0; pre_det = 1'b0; sync_det = 1'b0; uncorr_det = 1'b0; force_term = 1'b0;
    tp = (tp + 1) % 544;
  endtask

  task automatic adv(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic adv_to(int t);
    adv((t - tp + 544) % 544);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset rx_en", int'(rx_en), 0);
  endtask

  task automatic t_switch_on;
    en = 1'b1;
    @(negedge clk);
    tp = 0;
    chk("R2 switch-on mode", int'(mode), 1);
    chk("R2 switch-on rx_en", int'(rx_en), 1);
    chk_pos("R2 switch-on position");
    adv(40);
    chk_pos("R3 position after 40 strobes");
    chk("R4 still switch-on", int'(mode), 1);
    adv(1591);
    chk("R4 switch-on at 1631 strobes", int'(mode), 1);
    step(0, 0, 0, 0);
    chk("R4 timeout to carrier off", int'(mode), 6);
    chk("R11 bit cleared on entry", int'(bit_pos), 0);
  endtask

  task automatic t_carrier_off;
    chk("R11 scan window open", int'(rx_en), 1);
    adv(31);
    chk("R11 open at strobe 31", int'(rx_en), 1);
    adv(1);
    chk("R11 closed at strobe 32", int'(rx_en), 0);
    adv(8);
    step(0, 1, 0, 0);
    chk("R11 sync ignored while closed", int'(mode), 6);
    adv(535);
    chk("R11 reopens at strobe 576", int'(rx_en), 1);
    step(0, 1, 0, 0);
    tp = 32;
    chk("R11 sync accepted", int'(mode), 3);
    chk_pos("R6 realign to codeword 1");
  endtask

  task automatic t_data;
    chk("R7 masked frame 0 off", int'(rx_en), 0);
    adv_to(160);
    chk("R7 frame 2 first codeword on", int'(rx_en), 1);
    adv_to(200);
    chk("R7 frame 2 second codeword on", int'(rx_en), 1);
    adv_to(224);
    chk("R7 frame 3 off", int'(rx_en), 0);
    adv_to(0);
    chk("R7 sync slot on", int'(rx_en), 1);
    chk_pos("R3 batch wrap");
    chk("R8 data mode held", int'(mode), 3);
  endtask

  task automatic t_fail;
    step(0, 0, 1, 0);
    chk("R8 uncorrectable to data fail", int'(mode), 4);
    chk("R8 rx_en in sync slot", int'(rx_en), 1);
    step(0, 1, 1, 0);
    chk("R9 off-position pulses ignored", int'(mode), 4);
    adv_to(31);
    step(0, 1, 0, 0);
    tp = 32;
    chk("R9 sync at expected position", int'(mode), 3);
    chk_pos("R6 realign after data fail");
    step(0, 0, 1, 0);
    adv_to(31);
    step(0, 0, 0, 0);
    chk("R9 missing sync to fade", int'(mode), 5);
    chk_pos("R9 position continues");
  endtask

  task automatic t_fade;
    chk("R10 rx on at p32", int'(rx_en), 1);
    adv_to(40);
    chk("R10 rx off at p40", int'(rx_en), 0);
    adv_to(45);
    step(0, 1, 0, 0);
    chk("R10 sync outside window ignored", int'(mode), 5);
    adv_to(535);
    chk("R10 rx off at p535", int'(rx_en), 0);
    adv(1);
    chk("R10 rx on at p536", int'(rx_en), 1);
    adv_to(23);
    step(1, 0, 0, 0);
    chk("R10 preamble in window", int'(mode), 2);
  endtask

  task automatic t_preamble;
    chk("R2 rx on in preamble receive", int'(rx_en), 1);
    adv(100);
    step(1, 0, 0, 0);
    adv(543);
    chk("R5 held 543 strobes after preamble", int'(mode), 2);
    step(0, 0, 0, 0);
    chk("R5 timeout to carrier off", int'(mode), 6);
  endtask

  task automatic t_force;
    step(0, 1, 0, 0);
    tp = 32;
    chk("R11 sync at scan start", int'(mode), 3);
    @(negedge clk) force_term = 1'b1;
    @(negedge clk) force_term = 1'b0;
    chk("R12 force to data fail", int'(mode), 4);
    chk_pos("R12 force does not move position");
    chk("R8 fail rx off in masked frame", int'(rx_en), 0);
    adv_to(160);
    chk("R8 fail rx on in enabled frame", int'(rx_en), 1);
    adv_to(31);
    step(0, 1, 0, 1);
    chk("R12 force beats sync", int'(mode), 4);
  endtask

  task automatic t_fade_timeout;
    adv_to(31);
    step(0, 0, 0, 0);
    chk("R9 to fade", int'(mode), 5);
    adv(8159);
    chk("R10 fade held 8159 strobes", int'(mode), 5);
    step(0, 0, 0, 0);
    chk("R10 fade timeout", int'(mode), 6);
  endtask

  task automatic t_idle;
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R1 off mode", int'(mode), 0);
    chk("R1 off rx_en", int'(rx_en), 0);
    chk("R1 off position", int'(cw_pos) * 32 + int'(bit_pos), 0);
    step(1, 1, 0, 1);
    chk("R1 pulses ignored when off", int'(mode), 0);
    chk("R1 position held when off", int'(bit_pos), 0);
  endtask

  task automatic t_tie;
    en = 1'b1;
    @(negedge clk);
    tp = 0;
    chk("R2 second switch-on", int'(mode), 1);
    adv(1631);
    step(0, 1, 0, 0);
    tp = 32;
    chk("R13 sync beats timeout", int'(mode), 3);
    chk_pos("R13 realigned");
  endtask

  initial begin
    t_reset;
    t_switch_on;
    t_carrier_off;
    t_data;
    t_fail;
    t_fade;
    t_preamble;
    t_force;
    t_fade_timeout;
    t_idle;
    t_tie;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule